// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small on-chip cache of page table entries. It sits beside the address translation path and turns a virtual page number into a physical page number, together with the access-rights bits stored for that page. Sixteen entries are arranged as four sets of four ways. A request is compared against all four ways of one set in parallel. The hit flag, page number and rights appear one clock cycle after the request.

On a miss, the translation must be fetched from the page table in memory by logic outside this block. That logic then writes the complete entry back through the refill port. The block picks the way to overwrite by itself: it prefers a free way, and otherwise it uses a round-robin pointer kept per set. A flush input drops every stored translation at once, for example on a change of address space.

Top module: `tlb_set_assoc`

## Requirements
- R1: After reset no entry is valid, the round-robin pointers are 0 and `rspValid` is 0; every lookup misses until a refill is made.
- R2: The set is selected by `lookupVpn[1:0]` (and by `refillVpn[1:0]` for a refill). The tag compared and stored is VPN bits [7:2].
- R3: A lookup presented while `lookupValid` is 1 is answered on the next cycle with `rspValid` = 1. `rspHit` is 1 only if some way of the selected set holds a valid entry whose tag equals the request tag.
- R4: On a hit, `rspPpn` and `rspRights` carry the stored page number and rights bits unchanged. On a miss, both are 0.
- R5: A refill writes exactly one way of its set, and that way is the lowest-numbered invalid way when the set has any invalid way.
- R6: A refill into a full set overwrites the way named by that set's 2-bit pointer, then advances the pointer by one modulo 4. The pointers of other sets are not changed, and a refill into a set that is not full leaves its pointer unchanged.
- R7: A flush invalidates all 16 entries in one cycle and returns all pointers to 0. A lookup made in the cycle after the flush misses.
- R8: A refill presented in the same cycle as a flush is discarded.
- R9: A lookup and a refill (or flush) in the same cycle: the lookup is answered from the contents held before that cycle. The new entry is visible to lookups from the next cycle on.
- R10: If more than one way of a set matches, the lowest-numbered matching way supplies `rspPpn` and `rspRights`.
- R11: In the cycle after `lookupValid` was 0, `rspValid` and `rspHit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVpn | input | 8 | Virtual page number to translate |
| refillValid | input | 1 | Write one entry after a miss |
| refillVpn | input | 8 | Virtual page number of the refilled entry |
| refillPpn | input | 6 | Physical page number of the refilled entry |
| refillRights | input | 3 | Access-rights bits of the refilled entry, stored as given |
| flush | input | 1 | Invalidate all entries |
| rspValid | output | 1 | Response for the lookup of the previous cycle |
| rspHit | output | 1 | Translation found |
| rspPpn | output | 6 | Physical page number, 0 on miss |
| rspRights | output | 3 | Access-rights bits, 0 on miss |

## Verification
A lookup can fall in the same cycle as a refill or a flush that changes the very set being read. The directed part of the bench provokes three such collisions: a lookup of the VPN that is being refilled in that cycle, a lookup during a flush, and a refill during a flush. The random part keeps VPNs in a narrow range, so that same-set collisions happen often. Each response is judged against a bench model that applies a cycle's lookup before that cycle's refill or flush. The response must therefore show the old contents, and the next lookup must show the new ones.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic writeEn;   // write the victim way of the refill set
    logic flushAll;  // clear every valid bit
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refillValid,
  input  logic                  flush,
  input  logic [SET_W-1:0]      refillSet,
  input  logic [(1<<WAY_W)-1:0] setValid,
  output tlbStrobe_t            strobe,
  output logic [WAY_W-1:0]      victimWay
);

  localparam int SETS = 1 << SET_W;
  localparam int WAYS = 1 << WAY_W;

  logic [WAY_W-1:0] rrQ [SETS];
  logic [WAY_W-1:0] firstFree;
  logic [WAY_W-1:0] nextPtr;
  logic             setFull;

  assign setFull = &setValid;

  // The lowest-numbered invalid way wins.
  always_comb begin
    firstFree = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!setValid[w]) firstFree = WAY_W'(w);
    end
  end

  assign victimWay = setFull ? rrQ[refillSet] : firstFree;
  assign nextPtr   = rrQ[refillSet] + WAY_W'(1);

  always_comb begin
    strobe          = '0;
    strobe.flushAll = flush;
    strobe.writeEn  = refillValid && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      for (int s = 0; s < SETS; s++) rrQ[s] <= '0;
    end else if (strobe.writeEn && setFull) begin
      rrQ[refillSet] <= nextPtr;
    end
  end

  AST_PREFER_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && !setFull) |-> !setValid[victimWay]); // R5

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && setFull) |=> (rrQ[$past(refillSet)] == $past(nextPtr))); // R6

  AST_FLUSH_RESETS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (rrQ[0] == '0)); // R7

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VPN_W    = 8,
  parameter int SET_W    = 2,
  parameter int WAY_W    = 2,
  parameter int PPN_W    = 6,
  parameter int RIGHTS_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tlbStrobe_t            strobe,
  input  logic [WAY_W-1:0]      victimWay,
  input  logic                  lookupValid,
  input  logic [VPN_W-1:0]      lookupVpn,
  input  logic [VPN_W-1:0]      refillVpn,
  input  logic [PPN_W-1:0]      refillPpn,
  input  logic [RIGHTS_W-1:0]   refillRights,
  output logic [(1<<WAY_W)-1:0] refillSetValid,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic [PPN_W-1:0]      rspPpn,
  output logic [RIGHTS_W-1:0]   rspRights
);

  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 1 << WAY_W;
  localparam int TAG_W = VPN_W - SET_W;

  logic [WAYS-1:0]     validQ  [SETS];
  logic [TAG_W-1:0]    tagQ    [SETS][WAYS];
  logic [PPN_W-1:0]    ppnQ    [SETS][WAYS];
  logic [RIGHTS_W-1:0] rightsQ [SETS][WAYS];

  logic [SET_W-1:0] lkSet, rfSet;
  logic [TAG_W-1:0] lkTag, rfTag;
  logic [WAYS-1:0]  matchVec;
  logic [WAYS-1:0]  wrOneHot;
  logic [WAY_W-1:0] hitWay;
  logic             anyHit;
  logic             anyValid;

  assign lkSet = lookupVpn[SET_W-1:0];
  assign lkTag = lookupVpn[VPN_W-1:SET_W];
  assign rfSet = refillVpn[SET_W-1:0];
  assign rfTag = refillVpn[VPN_W-1:SET_W];

  assign refillSetValid = validQ[rfSet];

  // One comparator and one write decoder per way.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign matchVec[w] = validQ[lkSet][w] && (tagQ[lkSet][w] == lkTag);
    assign wrOneHot[w] = strobe.writeEn && (victimWay == WAY_W'(w));
  end

  assign anyHit = |matchVec;

  // The lowest matching way wins.
  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) hitWay = WAY_W'(w);
    end
  end

  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SETS; s++) anyValid = anyValid | (|validQ[s]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobe.writeEn) begin
      validQ[rfSet] <= validQ[rfSet] | wrOneHot;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (wrOneHot[w]) begin
        tagQ[rfSet][w]    <= rfTag;
        ppnQ[rfSet][w]    <= refillPpn;
        rightsQ[rfSet][w] <= refillRights;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspPpn    <= '0;
      rspRights <= '0;
    end else begin
      rspValid  <= lookupValid;
      rspHit    <= lookupValid && anyHit;
      rspPpn    <= (lookupValid && anyHit) ? ppnQ[lkSet][hitWay]    : '0;
      rspRights <= (lookupValid && anyHit) ? rightsQ[lkSet][hitWay] : '0;
    end
  end

  AST_ONE_WAY_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrOneHot)); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> !anyValid); // R7

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspPpn == '0 && rspRights == '0)); // R4

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid); // R11

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |=> validQ[$past(rfSet)][$past(victimWay)]); // R9

endmodule

// File: rtl/tlb_set_assoc.sv
module tlb_set_assoc
  import tlb_pkg::*;
#(
  parameter int VPN_W    = 8,
  parameter int SET_W    = 2,
  parameter int WAY_W    = 2,
  parameter int PPN_W    = 6,
  parameter int RIGHTS_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [VPN_W-1:0]    lookupVpn,
  input  logic                refillValid,
  input  logic [VPN_W-1:0]    refillVpn,
  input  logic [PPN_W-1:0]    refillPpn,
  input  logic [RIGHTS_W-1:0] refillRights,
  input  logic                flush,
  output logic                rspValid,
  output logic                rspHit,
  output logic [PPN_W-1:0]    rspPpn,
  output logic [RIGHTS_W-1:0] rspRights
);

  localparam int WAYS = 1 << WAY_W;

  tlbStrobe_t       strobe;
  logic [WAY_W-1:0] victimWay;
  logic [WAYS-1:0]  refillSetValid;

  tlb_ctrl #(
    .SET_W (SET_W),
    .WAY_W (WAY_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .refillValid (refillValid),
    .flush       (flush),
    .refillSet   (refillVpn[SET_W-1:0]),
    .setValid    (refillSetValid),
    .strobe      (strobe),
    .victimWay   (victimWay)
  );

  tlb_datapath #(
    .VPN_W    (VPN_W),
    .SET_W    (SET_W),
    .WAY_W    (WAY_W),
    .PPN_W    (PPN_W),
    .RIGHTS_W (RIGHTS_W)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .victimWay      (victimWay),
    .lookupValid    (lookupValid),
    .lookupVpn      (lookupVpn),
    .refillVpn      (refillVpn),
    .refillPpn      (refillPpn),
    .refillRights   (refillRights),
    .refillSetValid (refillSetValid),
    .rspValid       (rspValid),
    .rspHit         (rspHit),
    .rspPpn         (rspPpn),
    .rspRights      (rspRights)
  );

endmodule

// File: tb/tlb_set_assoc_tb_top.sv
`timescale 1ns/1ps
module tlb_set_assoc_tb_top;

  localparam int NSETS = 4;
  localparam int NWAYS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lookupValid = 1'b0;
  logic [7:0] lookupVpn = '0;
  logic       refillValid = 1'b0;
  logic [7:0] refillVpn = '0;
  logic [5:0] refillPpn = '0;
  logic [2:0] refillRights = '0;
  logic       flush = 1'b0;
  logic       rspValid, rspHit;
  logic [5:0] rspPpn;
  logic [2:0] rspRights;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the storage
  bit       mValid  [NSETS][NWAYS];
  bit [5:0] mTag    [NSETS][NWAYS];
  bit [5:0] mPpn    [NSETS][NWAYS];
  bit [2:0] mRights [NSETS][NWAYS];
  bit [1:0] mPtr    [NSETS];

  // Pending expectation: {valid, hit, ppn, rights}
  bit        pending = 0;
  bit [10:0] expRsp;
  string     expTag;

  always #4 clk = ~clk;

  tlb_set_assoc dut_i (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .refillValid(refillValid), .refillVpn(refillVpn),
    .refillPpn(refillPpn), .refillRights(refillRights),
    .flush(flush),
    .rspValid(rspValid), .rspHit(rspHit),
    .rspPpn(rspPpn), .rspRights(rspRights)
  );

  function automatic bit [7:0] vp(input int tag, input int set);
    return {tag[5:0], set[1:0]};
  endfunction

  function automatic bit [10:0] modelLookup(input bit lv, input bit [7:0] v);
    bit [10:0] r;
    r = '0;
    r[10] = lv;
    if (lv) begin
      for (int w = NWAYS - 1; w >= 0; w--) begin
        if (mValid[v[1:0]][w] && mTag[v[1:0]][w] == v[7:2])
          r = {1'b1, 1'b1, mPpn[v[1:0]][w], mRights[v[1:0]][w]};
      end
    end
    return r;
  endfunction

  task automatic modelUpdate(input bit rv, input bit [7:0] v, input bit [5:0] p,
                             input bit [2:0] rr, input bit fl);
    int s;
    int vic;
    s = int'(v[1:0]);
    if (fl) begin
      for (int i = 0; i < NSETS; i++) begin
        mPtr[i] = 0;
        for (int w = 0; w < NWAYS; w++) mValid[i][w] = 0;
      end
    end else if (rv) begin
      vic = -1;
      for (int w = NWAYS - 1; w >= 0; w--) if (!mValid[s][w]) vic = w;
      if (vic < 0) begin
        vic = int'(mPtr[s]);
        mPtr[s] = mPtr[s] + 2'd1;
      end
      mValid[s][vic] = 1;
      mTag[s][vic] = v[7:2];
      mPpn[s][vic] = p;
      mRights[s][vic] = rr;
    end
  endtask

  task automatic chk(input string tag, input bit [10:0] act, input bit [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual v=%0b h=%0b ppn=%02h r=%0d expected v=%0b h=%0b ppn=%02h r=%0d",
               tag, act[10], act[9], act[8:3], act[2:0], exp[10], exp[9], exp[8:3], exp[2:0]);
    end
  endtask

  task automatic step(input bit lv, input bit [7:0] lvpn, input bit rv, input bit [7:0] rvpn,
                      input bit [5:0] rp, input bit [2:0] rr, input bit fl, input string tag);
    @(negedge clk);
    if (pending) chk(expTag, {rspValid, rspHit, rspPpn, rspRights}, expRsp);
    lookupValid = lv; lookupVpn = lvpn;
    refillValid = rv; refillVpn = rvpn; refillPpn = rp; refillRights = rr;
    flush = fl;
    expRsp = modelLookup(lv, lvpn);
    expTag = tag;
    pending = 1;
    modelUpdate(rv, rvpn, rp, rr, fl);
  endtask

  task automatic look(input bit [7:0] v, input string tag);
    step(1, v, 0, 8'h00, 6'h00, 3'd0, 0, tag);
  endtask

  task automatic fill(input bit [7:0] v, input bit [5:0] p, input bit [2:0] rr, input string tag);
    step(0, 8'h00, 1, v, p, rr, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      mPtr[s] = 0;
      for (int w = 0; w < NWAYS; w++) mValid[s][w] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rspValid", {rspValid, 10'd0}, 11'd0);
    rstN = 1'b1;

    look(8'h00, "R1 empty after reset");
    look(8'h05, "R1 empty after reset");
    // R2/R3/R4: refill set1 tag1, then probe neighbours
    fill(vp(1, 1), 6'h2A, 3'd5, "R4 refill");
    look(vp(1, 1), "R3 R4 hit returns ppn/rights");
    look(vp(1, 2), "R2 other set misses");
    look(vp(2, 1), "R2 other tag misses");
    look(vp(0, 1), "R2 tag zero misses");
    step(0, vp(1, 1), 0, 8'h00, 6'h00, 3'd0, 0, "R11 idle");
    // R5: fill rest of set 1
    fill(vp(2, 1), 6'h11, 3'd1, "R5 fill");
    fill(vp(3, 1), 6'h12, 3'd2, "R5 fill");
    fill(vp(4, 1), 6'h13, 3'd3, "R5 fill");
    for (int t = 1; t <= 4; t++) look(vp(t, 1), "R5 all four ways held");
    // R6: round robin replaces way 0 then way 1
    fill(vp(5, 1), 6'h21, 3'd4, "R6 replace");
    look(vp(1, 1), "R6 way0 evicted");
    look(vp(5, 1), "R6 new entry hits");
    fill(vp(6, 1), 6'h22, 3'd6, "R6 replace");
    look(vp(2, 1), "R6 way1 evicted");
    look(vp(3, 1), "R6 way2 kept");
    // R9: lookup same VPN as refill in same cycle
    step(1, vp(7, 1), 1, vp(7, 1), 6'h33, 3'd7, 0, "R9 old contents on collision");
    look(vp(7, 1), "R9 new entry visible next cycle");
    // R7: flush with lookup in same cycle sees old, then empty
    step(1, vp(7, 1), 0, 8'h00, 6'h00, 3'd0, 1, "R9 lookup during flush");
    look(vp(7, 1), "R7 miss after flush");
    look(vp(5, 1), "R7 miss after flush");
    // R8: refill during flush dropped
    step(0, 8'h00, 1, vp(9, 2), 6'h09, 3'd1, 1, "R8 refill with flush");
    look(vp(9, 2), "R8 refill discarded");
    // R10: duplicate entries, lowest way wins
    fill(vp(3, 3), 6'h01, 3'd1, "R10 dup");
    fill(vp(3, 3), 6'h02, 3'd2, "R10 dup");
    look(vp(3, 3), "R10 lowest way wins");
    step(0, vp(3, 3), 0, 8'h00, 6'h00, 3'd0, 0, "R11 no request");

    // Random phase
    void'($urandom(32'd2718));
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] lv8, rv8;
      bit lv, rv, fl;
      lv8 = {3'b000, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
      rv8 = {3'b000, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
      lv = ($urandom_range(0, 3) != 0);
      rv = ($urandom_range(0, 2) == 0);
      fl = ($urandom_range(0, 99) == 0);
      step(lv, lv8, rv, rv8, 6'($urandom), 3'($urandom), fl, "R3 R4 R5 R6 R9 random");
    end
    step(0, 8'h00, 0, 8'h00, 6'h00, 3'd0, 0, "R11 drain");
    @(negedge clk);
    chk(expTag, {rspValid, rspHit, rspPpn, rspRights}, expRsp);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule